// File: doc/BRIEF.md
# Foldable Dual-Direction Tap Delay Line

This block holds the sample storage for a transversal filter. It has two chains of tap registers. Chain A carries samples from the first tap toward the last one. Chain B carries samples the other way, from the last tap back toward the first. Every tap register of both chains is visible on a wide output bus, so multiplier logic outside the block can read all taps in parallel. Multiplication, coefficient storage and summation are outside this block.

A mode bit, written in a configuration cycle, chooses between two arrangements:

- **Split mode:** the chains are two independent delay lines, each fed by its own input.
- **Folded mode:** chain A turns around at its far end. It feeds the second-to-last register of chain B and skips the last B register. The external B input is ignored in this mode. The result is a single 23-tap line that leaves on the B output.

Each chain shifts only when its own enable is high.

Top module: `fold_tap_line`

## Requirements
- R1: When `rst` is high at a clock edge, every A and B tap register becomes zero and the mode returns to split (mode bit 0).
- R2: At an edge with `enA` high, A tap 1 loads `dinA` and A tap k (k>1) loads A tap k-1. `outA` always shows A tap 12.
- R3: In split mode, at an edge with `enB` high, B tap 12 loads `dinB` and B tap k (k<12) loads B tap k+1. `outB` always shows B tap 1.
- R4: In folded mode, at an edge with `enB` high, B tap 11 loads A tap 12, B taps 10..1 shift as in R3, and B tap 12 holds. With both enables high, a sample on `dinA` therefore appears on `outB` 23 edges later.
- R5: In folded mode, `dinB` has no effect on any register or output.
- R6: At an edge where `enA` is low, all A taps hold. At an edge where `enB` is low, all B taps hold.
- R7: The mode bit loads `cfgFold` only at an edge where `cfgWr` is high. It governs shifting from the following edge on, and `cfgFold` is ignored at all other times.
- R8: On the tap buses, tap k of a chain (k = 1..12) sits at bits [10k-1 : 10k-10] of `tapA` and of `tapB`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWr | input | 1 | Configuration write strobe |
| cfgFold | input | 1 | Mode value captured on cfgWr (1 = folded) |
| enA | input | 1 | Shift enable for chain A |
| enB | input | 1 | Shift enable for chain B |
| dinA | input | 10 | Sample into A tap 1 |
| dinB | input | 10 | Sample into B tap 12 (split mode only) |
| tapA | output | 120 | All A tap registers, tap 1 in the low bits |
| tapB | output | 120 | All B tap registers, tap 1 in the low bits |
| outA | output | 10 | Chain A output (A tap 12) |
| outB | output | 10 | Chain B output (B tap 1) |

## Verification
The bench goes after the turn-around point, where three mistakes are likely:

- A design that fed B tap 12 instead of B tap 11 would give a 24-edge latency on the folded line.
- A design that kept `dinB` wired in during folded mode would corrupt B tap 12, or corrupt the line itself.
- A design that sampled `cfgFold` without `cfgWr` would change the route when the pin merely toggled.

The bench also runs each chain with its enable low while its input keeps changing, which catches a chain that drifts. It uses patterns whose values mark their tap position, which exposes any bit-slice mix-up on the tap buses.

// File: rtl/fold_tap_line_pkg.sv
package fold_tap_line_pkg;
  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic clear;   // synchronous clear of all taps
    logic shiftA;  // advance chain A this edge
    logic shiftB;  // advance chain B this edge
    logic fold;    // route A tap 12 into B tap 11
  } tflStrobe_t;
endpackage

// File: rtl/fold_tap_line_ctrl.sv
module fold_tap_line_ctrl
  import fold_tap_line_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgWr,
  input  logic       cfgFold,
  input  logic       enA,
  input  logic       enB,
  output tflStrobe_t strobe
);
  logic foldQ;

  always_ff @(posedge clk) begin
    if (rst)        foldQ <= 1'b0;
    else if (cfgWr) foldQ <= cfgFold;
  end

  always_comb begin
    strobe.clear  = rst;
    strobe.shiftA = enA & ~rst;
    strobe.shiftB = enB & ~rst;
    strobe.fold   = foldQ;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfgWr |=> $stable(foldQ)); // R7
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    cfgWr |=> (foldQ == $past(cfgFold))); // R7
  AST_CFG_RESET: assert property (@(posedge clk)
    rst |=> !foldQ); // R1
endmodule

// File: rtl/fold_tap_line_dp.sv
module fold_tap_line_dp
  import fold_tap_line_pkg::*;
#(
  parameter int TAPS  = 12,
  parameter int WIDTH = 10,
  localparam int BUSW = TAPS * WIDTH
)(
  input  logic             clk,
  input  logic             rst,
  input  tflStrobe_t       strobe,
  input  logic [WIDTH-1:0] dinA,
  input  logic [WIDTH-1:0] dinB,
  output logic [BUSW-1:0]  tapA,
  output logic [BUSW-1:0]  tapB
);
  logic [WIDTH-1:0] regA [TAPS];
  logic [WIDTH-1:0] regB [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : gTap
    // Chain A: tap 1 takes the input, each later tap takes its lower neighbour
    if (i == 0) begin : gA1
      always_ff @(posedge clk) begin
        if (strobe.clear)       regA[i] <= '0;
        else if (strobe.shiftA) regA[i] <= dinA;
      end
    end else begin : gAk
      always_ff @(posedge clk) begin
        if (strobe.clear)       regA[i] <= '0;
        else if (strobe.shiftA) regA[i] <= regA[i-1];
      end
    end

    // Chain B: the last tap takes the input only in split mode
    if (i == TAPS-1) begin : gBLast
      always_ff @(posedge clk) begin
        if (strobe.clear)                       regB[i] <= '0;
        else if (strobe.shiftB && !strobe.fold) regB[i] <= dinB;
      end
    end else if (i == TAPS-2) begin : gBTurn
      // Turn-around point: in folded mode A's last tap bypasses B's last tap
      always_ff @(posedge clk) begin
        if (strobe.clear)       regB[i] <= '0;
        else if (strobe.shiftB) regB[i] <= strobe.fold ? regA[TAPS-1] : regB[i+1];
      end
    end else begin : gBk
      always_ff @(posedge clk) begin
        if (strobe.clear)       regB[i] <= '0;
        else if (strobe.shiftB) regB[i] <= regB[i+1];
      end
    end

    assign tapA[i*WIDTH +: WIDTH] = regA[i];
    assign tapB[i*WIDTH +: WIDTH] = regB[i];
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    rst |=> (tapA == '0 && tapB == '0)); // R1
  AST_A_ENTRY: assert property (@(posedge clk) disable iff (rst)
    strobe.shiftA |=> (tapA[WIDTH-1:0] == $past(dinA))); // R2
  AST_B_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (strobe.shiftB && !strobe.fold) |=> (tapB[BUSW-1 -: WIDTH] == $past(dinB))); // R3
  AST_FOLD_LINK: assert property (@(posedge clk) disable iff (rst)
    (strobe.shiftB && strobe.fold) |=> (regB[TAPS-2] == $past(regA[TAPS-1]))); // R4
  AST_FOLD_B_IGNORED: assert property (@(posedge clk) disable iff (rst)
    strobe.fold |=> $stable(regB[TAPS-1])); // R5
  AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.shiftA |=> $stable(tapA)); // R6
  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.shiftB |=> $stable(tapB)); // R6
endmodule

// File: rtl/fold_tap_line.sv
module fold_tap_line #(
  parameter int TAPS  = 12,
  parameter int WIDTH = 10,
  localparam int BUSW = TAPS * WIDTH
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWr,
  input  logic             cfgFold,
  input  logic             enA,
  input  logic             enB,
  input  logic [WIDTH-1:0] dinA,
  input  logic [WIDTH-1:0] dinB,
  output logic [BUSW-1:0]  tapA,
  output logic [BUSW-1:0]  tapB,
  output logic [WIDTH-1:0] outA,
  output logic [WIDTH-1:0] outB
);
  fold_tap_line_pkg::tflStrobe_t strobe;

  fold_tap_line_ctrl uCtrl (
    .clk(clk), .rst(rst), .cfgWr(cfgWr), .cfgFold(cfgFold),
    .enA(enA), .enB(enB), .strobe(strobe)
  );

  fold_tap_line_dp #(.TAPS(TAPS), .WIDTH(WIDTH)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .dinA(dinA), .dinB(dinB), .tapA(tapA), .tapB(tapB)
  );

  assign outA = tapA[BUSW-1 -: WIDTH];
  assign outB = tapB[WIDTH-1:0];
endmodule

// File: tb/fold_tap_line_test.sv
module fold_tap_line_test;
  localparam int TAPS = 12;
  localparam int W    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, cfgWr = 1'b0, cfgFold = 1'b0, enA = 1'b0, enB = 1'b0;
  logic [W-1:0] dinA = '0, dinB = '0;
  logic [TAPS*W-1:0] tapA, tapB;
  logic [W-1:0] outA, outB;

  int vectors = 0;
  int fails = 0;
  logic [W-1:0] mA [TAPS];
  logic [W-1:0] mB [TAPS];
  logic mFold = 1'b0;

  always #2 clk = ~clk;

  fold_tap_line uut (
    .clk(clk), .rst(rst), .cfgWr(cfgWr), .cfgFold(cfgFold),
    .enA(enA), .enB(enB), .dinA(dinA), .dinB(dinB),
    .tapA(tapA), .tapB(tapB), .outA(outA), .outB(outB)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every tap and both chain outputs against the reference model (R8 layout)
  task automatic compareAll(input string req);
    for (int i = 0; i < TAPS; i++) begin
      chk({req, " R8 tapA"}, tapA[i*W +: W], mA[i]);
      chk({req, " R8 tapB"}, tapB[i*W +: W], mB[i]);
    end
    chk({req, " R2 outA"}, outA, mA[TAPS-1]);
    chk({req, " R3 outB"}, outB, mB[0]);
  endtask

  // One clock: drive inputs at the falling edge, update model at the rising edge, then compare
  task automatic step(input logic r, input logic wr, input logic fb, input logic ea,
                      input logic eb, input logic [W-1:0] a, input logic [W-1:0] b,
                      input string req);
    logic [W-1:0] nA [TAPS];
    logic [W-1:0] nB [TAPS];
    @(negedge clk);
    rst = r; cfgWr = wr; cfgFold = fb; enA = ea; enB = eb; dinA = a; dinB = b;
    @(posedge clk);
    nA = mA; nB = mB;
    if (r) begin
      for (int i = 0; i < TAPS; i++) begin nA[i] = '0; nB[i] = '0; end
    end else begin
      if (ea) begin
        nA[0] = a;
        for (int i = 1; i < TAPS; i++) nA[i] = mA[i-1];
      end
      if (eb) begin
        for (int i = 0; i < TAPS-2; i++) nB[i] = mB[i+1];
        nB[TAPS-2] = mFold ? mA[TAPS-1] : mB[TAPS-1];
        if (!mFold) nB[TAPS-1] = b;
      end
    end
    mA = nA; mB = nB;
    if (r) mFold = 1'b0;
    else if (wr) mFold = fb;
    #1;
    compareAll(req);
  endtask

  task automatic testReset();
    step(1, 0, 0, 1, 1, 10'h3FF, 10'h2AA, "R1 reset");
    step(1, 0, 0, 0, 0, 10'h155, 10'h0F0, "R1 reset hold");
  endtask

  task automatic testSplitShift();
    for (int k = 0; k < 14; k++)
      step(0, 0, 0, 1, 1, W'(k + 1), W'(100 + k), "R2/R3 split shift");
    chk("R2 outA oldest", outA, W'(3));
    chk("R3 outB oldest", outB, W'(102));
  endtask

  task automatic testEnableHold();
    for (int k = 0; k < 4; k++)
      step(0, 0, 0, 0, 1, W'(500 + k), W'(600 + k), "R6 A hold");
    for (int k = 0; k < 4; k++)
      step(0, 0, 0, 1, 0, W'(700 + k), W'(800 + k), "R6 B hold");
    step(0, 0, 0, 0, 0, 10'h3FF, 10'h3FF, "R6 both hold");
  endtask

  task automatic testCfgIgnored();
    // Toggle cfgFold without a write: route must stay split
    step(0, 0, 1, 1, 1, 10'd11, 10'd900, "R7 no write");
    step(0, 0, 1, 1, 1, 10'd12, 10'd901, "R7 no write");
    chk("R7 B tap12 from dinB", tapB[TAPS*W-1 -: W], 10'd901);
  endtask

  task automatic testFolded();
    step(0, 1, 1, 0, 0, 10'd0, 10'd0, "R7 write fold");
    step(1, 0, 0, 0, 0, 10'd0, 10'd0, "R1 clear before fold");
    step(0, 1, 1, 0, 0, 10'd0, 10'd0, "R7 write fold");
    for (int k = 0; k < 30; k++)
      step(0, 0, 0, 1, 1, W'(200 + k), W'(1000 - 7 * k), "R4/R5 folded");
    // Sample 200+k entered at step k; after 30 edges, outB holds the one 23 edges old
    chk("R4 23-tap latency", outB, W'(200 + 30 - 23));
    chk("R5 B tap12 untouched", tapB[TAPS*W-1 -: W], 10'd0);
    step(0, 0, 0, 0, 1, 10'd5, 10'h3FF, "R5 dinB ignored");
    step(0, 0, 0, 1, 0, 10'd6, 10'h155, "R6 folded hold");
  endtask

  task automatic testUnfold();
    step(0, 1, 0, 1, 1, 10'd40, 10'd41, "R7 write split");
    step(0, 0, 0, 1, 1, 10'd42, 10'd43, "R3 split again");
    chk("R3 B tap12 from dinB", tapB[TAPS*W-1 -: W], 10'd43);
    for (int k = 0; k < 12; k++)
      step(0, 0, 1, 1, 1, W'(k * 37), W'(k * 53), "R2/R3 mixed");
  endtask

  initial begin : wd
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < TAPS; i++) begin mA[i] = '0; mB[i] = '0; end
    testReset();
    testSplitShift();
    testEnableHold();
    testCfgIgnored();
    testFolded();
    testUnfold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule